// File: doc/BRIEF.md
# Bus Master Latency Timer

This block bounds how long a bus master may hold the bus after the arbiter has taken its grant away. When the master begins a transaction, the programmed latency value is captured into a down-counter. The counter then falls by one on every bus clock and stops at zero.

A terminate request goes to the master state machine only when two conditions hold together: the count has run out, and the grant is seen removed. A master that still holds its grant may run past the expired count. A master whose grant is pulled while time remains keeps transferring until the count reaches zero.

The request is registered. It stays up until the master drops FRAME. If a transaction finishes on its own before the request fires, the timer has no effect on it.

Top module: `bm_latency_timer`

## Requirements
- R1: While reset is applied, and after it until a transaction starts, `term_req` is low.
- R2: On the clock that first samples `frame_active` high (edge 0), the counter loads `lat_value`. It then drops by one per clock. With `grant` low throughout, `term_req` first reads high after edge `lat_value`+1.
- R3: If the count has reached zero while `grant` is high, `term_req` stays low. It first reads high after the first edge that samples `grant` low.
- R4: If `grant` is sampled low while the count is non-zero, `term_req` stays low until the count reaches zero. It rises at the edge after that.
- R5: The counter holds at zero and never wraps, however long an expired transaction keeps its grant. A grant removal after that wait still terminates at the next edge.
- R6: A `lat_value` of 0 counts as expired at once: with `grant` low, `term_req` reads high after edge 1 of the transaction.
- R7: Once high, `term_req` stays high while `frame_active` is high, even if `xfer_done` pulses later. It clears on the first edge that samples `frame_active` low.
- R8: If `xfer_done` is sampled high, or `frame_active` falls, before the termination conditions are met, `term_req` stays low for the rest of that transaction.
- R9: A change to `lat_value` during a transaction does not alter the running count. The new value applies from the next rising edge of `frame_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lat_value | input | CNT_W | Programmed latency value in bus clocks |
| frame_active | input | 1 | Master is driving FRAME (active high) |
| xfer_done | input | 1 | Pulse: master finishes the transaction on its own |
| grant | input | 1 | Bus grant from the arbiter (active high) |
| term_req | output | 1 | Registered request to terminate the transaction |

## Verification
The bench builds the block with the default 8-bit counter. This allows a full-scale load of 255, so a single long transaction shows the count running through its entire range. It also allows a grant held for about two hundred clocks past expiry, long enough to expose a counter that wraps instead of saturating. The smallest values, 0 and 1, reach the immediate-expiry case and the case where the value is rewritten mid-transaction.

// File: rtl/lt_pkg.sv
package lt_pkg;
    typedef struct packed {
        logic frame;
    } edge_state_t;

    typedef struct packed {
        logic running;
        logic term;
    } ctl_state_t;
endpackage

// File: rtl/lt_frame_edge.sv
module lt_frame_edge
    import lt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_active,
    output logic frame_start
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.frame  = frame_active;
        frame_start = frame_active & ~st_q.frame;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - ONE;
        zero  = (cnt_q == '0);
        count = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lt_term_ctl.sv
module lt_term_ctl
    import lt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_active,
    input  logic xfer_done,
    input  logic grant,
    input  logic cnt_zero,
    output logic term_req
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.running = frame_active & ~xfer_done & (frame_start | st_q.running);
        if (!frame_active)
            st_d.term = 1'b0;
        else if (!st_q.term)
            st_d.term = st_q.running & cnt_zero & ~grant & ~xfer_done;
        term_req = st_q.term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bm_latency_timer.sv
module bm_latency_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] lat_value,
    input  logic             frame_active,
    input  logic             xfer_done,
    input  logic             grant,
    output logic             term_req
);
    logic             frame_start;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;

    lt_frame_edge u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .frame_start  (frame_start)
    );

    lt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_start),
        .load_val (lat_value),
        .count    (cnt_q),
        .zero     (cnt_zero)
    );

    lt_term_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .frame_active (frame_active),
        .xfer_done    (xfer_done),
        .grant        (grant),
        .cnt_zero     (cnt_zero),
        .term_req     (term_req)
    );
endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] lat_value,
    input logic             frame_active,
    input logic             grant,
    input logic             frame_start,
    input logic [CNT_W-1:0] cnt,
    input logic             term_req
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always @(posedge clk) begin
        if (!rst_n) assert_reset_idle_R1: assert (term_req == 1'b0);
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> cnt == $past(lat_value));

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && cnt != '0) |=> cnt == $past(cnt) - ONE);

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && cnt == '0) |=> cnt == '0);

    assert_needs_grant_gone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_req) |-> $past(!grant));

    assert_clear_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !term_req);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (term_req && frame_active) |=> term_req);
endmodule

bind bm_latency_timer lt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lat_value    (lat_value),
    .frame_active (frame_active),
    .grant        (grant),
    .frame_start  (frame_start),
    .cnt          (cnt_q),
    .term_req     (term_req)
);

// File: tb/tb_bm_latency_timer.sv
module tb_bm_latency_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int NVEC       = 9;

    // columns: value, grant-drop cycle, frame length, xfer_done cycle (-1 none), requirement
    localparam int VEC [NVEC][5] = '{
        '{5,   0,   20, -1, 2},   // R2 plain expiry
        '{3,   10,  20, -1, 3},   // R3 expired, grant held
        '{8,   2,   20, -1, 4},   // R4 grant gone early
        '{0,   0,   6,  -1, 6},   // R6 zero value
        '{10,  0,   8,  -1, 8},   // R8 frame ends first
        '{4,   0,   20, 2,  8},   // R8 done pulse first
        '{255, 0,   260, -1, 2},  // R2 full scale
        '{2,   200, 210, -1, 5},  // R5 long saturation
        '{6,   3,   15, 9,  7}    // R7 done after term
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] lat_value = '0;
    logic             frame_active = 1'b0;
    logic             xfer_done = 1'b0;
    logic             grant = 1'b1;
    logic             term_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bm_latency_timer #(.CNT_W(CNT_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lat_value    (lat_value),
        .frame_active (frame_active),
        .xfer_done    (xfer_done),
        .grant        (grant),
        .term_req     (term_req)
    );

    task automatic check(input logic act, input logic exp, input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_active = 1'b0; xfer_done = 1'b0; grant = 1'b1;
            @(posedge clk); #1;
        end
    endtask

    task automatic run_vec(input int v, input int g, input int l, input int d, input int req);
        int e;
        e = (v + 1 > g) ? v + 1 : g;
        if (e >= l) e = -1;
        if (d >= 0 && e >= 0 && d <= e) e = -1;
        for (int c = 0; c <= l + 1; c++) begin
            @(negedge clk);
            lat_value    = CNT_W'(v);
            frame_active = (c < l);
            grant        = (c >= l) ? 1'b1 : (c < g);
            xfer_done    = (c == d);
            @(posedge clk); #1;
            check(term_req, (e >= 0 && c >= e && c < l), req,
                  $sformatf("v=%0d g=%0d cycle %0d", v, g, c));
        end
        idle(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds output low even with frame high and grant low
        frame_active = 1'b1; grant = 1'b0;
        repeat (3) @(posedge clk);
        #1 check(term_req, 1'b0, 1, "during reset");
        @(negedge clk); frame_active = 1'b0; grant = 1'b1; rst_n = 1'b1;
        idle(2);
        check(term_req, 1'b0, 1, "after reset");

        for (int k = 0; k < NVEC; k++)
            run_vec(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4]);

        // R9: rewrite value mid-transaction; running count keeps value 6
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            frame_active = 1'b1; grant = 1'b0; xfer_done = 1'b0;
            lat_value = (c < 2) ? CNT_W'(6) : CNT_W'(1);
            @(posedge clk); #1;
            check(term_req, c >= 7, 9, $sformatf("rewrite cycle %0d", c));
        end
        idle(3);
        check(term_req, 1'b0, 7, "cleared after frame low");
        // R9: the new value 1 applies to the next transaction
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            frame_active = 1'b1; grant = 1'b0;
            @(posedge clk); #1;
            check(term_req, c >= 2, 9, $sformatf("new value cycle %0d", c));
        end
        // R1: reset in the middle of a termination drops the request
        @(negedge clk); rst_n = 1'b0;
        #1 check(term_req, 1'b0, 1, "reset mid-termination");
        @(negedge clk); rst_n = 1'b1; frame_active = 1'b0; grant = 1'b1;
        idle(2);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule